// File: doc/BRIEF.md
# Inverted-Feedback Signature Register with Scan Mode

This block compacts a stream of parallel response words from a circuit under test into an n-bit signature. It uses an internal exclusive-or feedback structure set by a characteristic polynomial. The bit fed back from the last stage is inverted before it reaches the tapped stages. As a result, an all-zero state does not lock the register when it runs on its own. A stuck-at fault on the feedback path therefore shows up in the signature.

Two independent gate controls select the operating mode:

| Feedback gate | Input gate | Mode |
|---|---|---|
| 0 | 0 | Shift register from serial input to serial output. The register can sit inside a scan chain and be checked with a repeating pattern. |
| 1 | 0 | Autonomous run under inverted feedback, so a known seed can be compared with a precomputed state sequence. |
| 1 | 1 | Full compaction. |
| 0 | 1 | Serial input plus gated response word, with no feedback. |

A synchronous clear and a seed load set the starting state. The full signature is visible in parallel at all times.

Top module: `invfb_sigreg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes all zeros. `rst` takes priority over every other control.
- R2: When `loadEn` is high and `rst` is low, the register takes `seedIn` on the next edge, whatever the gate controls are.
- R3: With `fbGate`=0 and `dataGate`=0, stage 0 (`signature[0]`) takes `serialIn` and each stage k takes stage k-1. `respIn` has no effect.
- R4: `serialOut` always equals the last stage, `signature[WIDTH-1]`.
- R5: In shift mode, a repeating serial pattern 0,0,1,1 on `serialIn` appears unchanged on `serialOut`, delayed by exactly WIDTH clocks.
- R6: With `fbGate`=1 and `dataGate`=0, let the feedback bit be the inverse of `signature[WIDTH-1]`. Stage 0 takes the feedback bit. Stage k (k≥1) takes stage k-1 XOR the feedback bit when polynomial coefficient `POLY[k]` is 1. `respIn` has no effect.
- R7: With both gates at 1, each stage k additionally XORs in `respIn[k]` on top of the R6 behaviour.
- R8: With `fbGate`=0 and `dataGate`=1, stage 0 takes `serialIn` XOR `respIn[0]`. Stage k takes stage k-1 XOR `respIn[k]`. No feedback bit is applied.
- R9: The feedback is inverted. From the all-zero state, one autonomous clock yields 1 in stage 0 and in every stage k with `POLY[k]`=1. For the default 8-bit polynomial (`POLY`=8'h1D) this is 8'h1D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear to all zeros |
| loadEn | input | 1 | Load strobe for the seed word |
| seedIn | input | WIDTH | Initial state loaded by `loadEn` |
| fbGate | input | 1 | 1 lets the inverted feedback bit reach the stages |
| dataGate | input | 1 | 1 lets the response word into the stages |
| serialIn | input | 1 | Serial input into stage 0 when feedback is gated off |
| respIn | input | WIDTH | Parallel response word from the circuit under test |
| signature | output | WIDTH | Current register contents, stage 0 at bit 0 |
| serialOut | output | 1 | Last stage of the register |

## Verification
Every cycle, the assertions check how each mode moves the register one edge ahead:
- the clear and load results;
- the one-place shift and the serial output in shift mode;
- the inverted bit entering stage 0 under feedback, with and without the response word;
- the serial-plus-response entry into stage 0 when only the input gate is open.

The tapped middle stages for a given polynomial, the delayed 0011 pattern across the whole chain and the fixed value after one autonomous step from zero can only be shown by the bench scenarios. The bench compares three instances with different primitive polynomials against a behavioural model on every clock.

// File: rtl/invfb_sigreg_pkg.sv
package invfb_sigreg_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT   = 2'b00,
    MODE_GATEDIN = 2'b01,
    MODE_AUTON   = 2'b10,
    MODE_COMPACT = 2'b11
  } sigMode_t;

  typedef struct packed {
    logic clear;
    logic load;
    logic feedOn;
    logic dataOn;
  } sigCtrl_t;

endpackage

// File: rtl/invfb_sigreg_ctrl.sv
module invfb_sigreg_ctrl
  import invfb_sigreg_pkg::*;
(
  input  logic     rst,
  input  logic     loadEn,
  input  logic     fbGate,
  input  logic     dataGate,
  output sigCtrl_t ctrl
);

  sigMode_t mode;

  always_comb begin
    mode = sigMode_t'({fbGate, dataGate});
  end

  always_comb begin
    ctrl = '0;
    ctrl.clear = rst;
    ctrl.load  = ~rst & loadEn;
    unique case (mode)
      MODE_SHIFT: begin
        ctrl.feedOn = 1'b0;
        ctrl.dataOn = 1'b0;
      end
      MODE_GATEDIN: begin
        ctrl.feedOn = 1'b0;
        ctrl.dataOn = 1'b1;
      end
      MODE_AUTON: begin
        ctrl.feedOn = 1'b1;
        ctrl.dataOn = 1'b0;
      end
      MODE_COMPACT: begin
        ctrl.feedOn = 1'b1;
        ctrl.dataOn = 1'b1;
      end
      default: begin
        ctrl.feedOn = 1'b0;
        ctrl.dataOn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/invfb_sigreg_dp.sv
module invfb_sigreg_dp
  import invfb_sigreg_pkg::*;
#(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1D
) (
  input  logic             clk,
  input  sigCtrl_t         ctrl,
  input  logic [WIDTH-1:0] seedIn,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] respIn,
  output logic [WIDTH-1:0] stateQ,
  output logic             lastBit
);

  localparam int LAST = WIDTH - 1;

  logic             fbBit;
  logic [WIDTH-1:0] gatedResp;
  logic [WIDTH-1:0] chainIn;
  logic [WIDTH-1:0] stateNext;

  assign fbBit     = ctrl.feedOn & ~stateQ[LAST];
  assign gatedResp = respIn & {WIDTH{ctrl.dataOn}};

  assign chainIn[0] = ctrl.feedOn ? fbBit : serialIn;

  for (genvar k = 1; k < WIDTH; k++) begin : g_stage
    if (POLY[k]) begin : g_tap
      assign chainIn[k] = stateQ[k-1] ^ fbBit;
    end else begin : g_plain
      assign chainIn[k] = stateQ[k-1];
    end
  end

  always_comb begin
    if (ctrl.clear) begin
      stateNext = '0;
    end else if (ctrl.load) begin
      stateNext = seedIn;
    end else begin
      stateNext = chainIn ^ gatedResp;
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= stateNext;
  end

  assign lastBit = stateQ[LAST];

endmodule

// File: rtl/invfb_sigreg.sv
module invfb_sigreg
  import invfb_sigreg_pkg::*;
#(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] seedIn,
  input  logic             fbGate,
  input  logic             dataGate,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] respIn,
  output logic [WIDTH-1:0] signature,
  output logic             serialOut
);

  sigCtrl_t ctrl;

  invfb_sigreg_ctrl u_ctrl (
    .rst      (rst),
    .loadEn   (loadEn),
    .fbGate   (fbGate),
    .dataGate (dataGate),
    .ctrl     (ctrl)
  );

  invfb_sigreg_dp #(
    .WIDTH (WIDTH),
    .POLY  (POLY)
  ) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .seedIn   (seedIn),
    .serialIn (serialIn),
    .respIn   (respIn),
    .stateQ   (signature),
    .lastBit  (serialOut)
  );

endmodule

// File: rtl/invfb_sigreg_chk.sv
module invfb_sigreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             loadEn,
  input logic [WIDTH-1:0] seedIn,
  input logic             fbGate,
  input logic             dataGate,
  input logic             serialIn,
  input logic [WIDTH-1:0] respIn,
  input logic [WIDTH-1:0] signature,
  input logic             serialOut
);

  logic plainStep;
  assign plainStep = ~rst & ~loadEn;

  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (signature == '0));

  assert_seed_R2: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (signature == $past(seedIn)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (plainStep && !fbGate && !dataGate) |=>
      (signature == {$past(signature[WIDTH-2:0]), $past(serialIn)}));

  assert_serial_out_R4: assert property (@(posedge clk) disable iff (rst)
    (plainStep && !fbGate && !dataGate) |=> (serialOut == $past(signature[WIDTH-2])));

  assert_auton_head_R6: assert property (@(posedge clk) disable iff (rst)
    (plainStep && fbGate && !dataGate) |=> (signature[0] == !$past(serialOut)));

  assert_compact_head_R7: assert property (@(posedge clk) disable iff (rst)
    (plainStep && fbGate && dataGate) |=>
      (signature[0] == ($past(respIn[0]) ^ !$past(serialOut))));

  assert_gatedin_head_R8: assert property (@(posedge clk) disable iff (rst)
    (plainStep && !fbGate && dataGate) |=>
      (signature[0] == ($past(respIn[0]) ^ $past(serialIn))));

endmodule

bind invfb_sigreg invfb_sigreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loadEn    (loadEn),
  .seedIn    (seedIn),
  .fbGate    (fbGate),
  .dataGate  (dataGate),
  .serialIn  (serialIn),
  .respIn    (respIn),
  .signature (signature),
  .serialOut (serialOut)
);

// File: tb/test_invfb_sigreg.sv
`timescale 1ns/1ps
module test_invfb_sigreg;

  localparam int NINST = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [7:0] seedIn = '0;
  logic       fbGate = 1'b0;
  logic       dataGate = 1'b0;
  logic       serialIn = 1'b0;
  logic [7:0] respIn = '0;

  logic [7:0] sigA;
  logic [4:0] sigB;
  logic [3:0] sigC;
  logic       soA, soB, soC;

  int         widths [NINST] = '{8, 5, 4};
  logic [7:0] polys  [NINST] = '{8'h1D, 8'h05, 8'h03};
  logic [7:0] model  [NINST];
  logic [7:0] dutSig [NINST];
  logic       dutSo  [NINST];

  int tests = 0;
  int failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // 8-bit: x^8+x^4+x^3+x^2+1
  invfb_sigreg #(.WIDTH(8), .POLY(8'h1D)) i_invfb_sigreg (
    .clk(clk), .rst(rst), .loadEn(loadEn), .seedIn(seedIn),
    .fbGate(fbGate), .dataGate(dataGate), .serialIn(serialIn),
    .respIn(respIn), .signature(sigA), .serialOut(soA));

  // 5-bit: x^5+x^2+1
  invfb_sigreg #(.WIDTH(5), .POLY(5'h05)) i_invfb_sigreg_w5 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .seedIn(seedIn[4:0]),
    .fbGate(fbGate), .dataGate(dataGate), .serialIn(serialIn),
    .respIn(respIn[4:0]), .signature(sigB), .serialOut(soB));

  // 4-bit: x^4+x+1
  invfb_sigreg #(.WIDTH(4), .POLY(4'h3)) i_invfb_sigreg_w4 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .seedIn(seedIn[3:0]),
    .fbGate(fbGate), .dataGate(dataGate), .serialIn(serialIn),
    .respIn(respIn[3:0]), .signature(sigC), .serialOut(soC));

  assign dutSig[0] = sigA;
  assign dutSig[1] = {3'b000, sigB};
  assign dutSig[2] = {4'b0000, sigC};
  assign dutSo[0]  = soA;
  assign dutSo[1]  = soB;
  assign dutSo[2]  = soC;

  function automatic logic [7:0] widthMask(int w);
    return 8'((16'd1 << w) - 16'd1);
  endfunction

  // Behavioural next-state model written from the requirements.
  function automatic logic [7:0] refNext(int w, logic [7:0] poly, logic [7:0] st,
                                         bit r, bit ld, logic [7:0] sd, bit c1,
                                         bit c2, bit si, logic [7:0] d);
    logic [7:0] nx;
    bit fb;
    bit entry;
    if (r) return 8'h00;
    if (ld) return sd & widthMask(w);
    fb = c1 && !st[w-1];
    nx = 8'h00;
    for (int k = 0; k < w; k++) begin
      if (k == 0) entry = c1 ? fb : si;
      else        entry = st[k-1] ^ (poly[k] && fb);
      nx[k] = entry ^ (c2 && d[k]);
    end
    return nx;
  endfunction

  task automatic check(string tag, int inst, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s inst%0d: actual %h expected %h", tag, inst, got, exp);
    end
  endtask

  task automatic step(string tag, bit r, bit ld, logic [7:0] sd, bit c1, bit c2,
                      bit si, logic [7:0] d);
    rst = r; loadEn = ld; seedIn = sd; fbGate = c1; dataGate = c2;
    serialIn = si; respIn = d;
    @(posedge clk);
    for (int i = 0; i < NINST; i++)
      model[i] = refNext(widths[i], polys[i], model[i], r, ld, sd, c1, c2, si, d);
    @(negedge clk);
    for (int i = 0; i < NINST; i++) begin
      check(tag, i, dutSig[i], model[i]);
      check("R4", i, {7'b0, dutSo[i]}, {7'b0, model[i][widths[i]-1]});
    end
  endtask

  function automatic logic [7:0] rnd8();
    return 8'($urandom);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NINST; i++) model[i] = 8'h00;
    @(negedge clk);

    // R1: clear, even with load and gates active
    repeat (2) step("R1", 1, 1, 8'hA5, 1, 1, 1, 8'hFF);
    for (int i = 0; i < NINST; i++) check("R1 zero", i, dutSig[i], 8'h00);

    // R9: one autonomous step from zero gives the tap pattern
    step("R9", 0, 0, 8'h00, 1, 0, 0, 8'hFF);
    check("R9 fixed", 0, dutSig[0], 8'h1D);
    check("R9 fixed", 1, dutSig[1], 8'h05);
    check("R9 fixed", 2, dutSig[2], 8'h03);

    // R6: autonomous run, response word must not matter
    repeat (40) step("R6", 0, 0, 8'h00, 1, 0, $urandom % 2, rnd8());

    // R2: seed load overrides mode
    for (int n = 0; n < 8; n++) begin
      logic [7:0] s;
      s = rnd8();
      step("R2", 0, 1, s, n % 2, (n / 2) % 2, $urandom % 2, rnd8());
      check("R2 seed", 0, dutSig[0], s);
    end

    // R7: full compaction
    step("R2", 0, 1, 8'h3C, 0, 0, 0, 8'h00);
    repeat (300) step("R7", 0, 0, 8'h00, 1, 1, $urandom % 2, rnd8());

    // R8: serial plus response, no feedback
    repeat (100) step("R8", 0, 0, 8'h00, 0, 1, $urandom % 2, rnd8());

    // R3: shift mode with random serial data, response ignored
    repeat (100) step("R3", 0, 0, 8'h00, 0, 0, $urandom % 2, rnd8());

    // R5: 0011 pattern through the chain
    step("R1", 1, 0, 8'h00, 0, 0, 0, 8'h00);
    for (int t = 1; t <= 48; t++) begin
      step("R5", 0, 0, 8'h00, 0, 0, ((t - 1) % 4) >= 2, rnd8());
      for (int i = 0; i < NINST; i++) begin
        if (t >= widths[i]) begin
          bit e;
          e = ((t - widths[i]) % 4) >= 2;
          check("R5 pattern", i, {7'b0, dutSo[i]}, {7'b0, e});
        end
      end
    end

    // Mixed traffic across all modes
    for (int n = 0; n < 3000; n++) begin
      int roll;
      roll = int'($urandom % 100);
      step("R10mix", roll < 2, (roll >= 2) && (roll < 6), rnd8(),
           $urandom % 2, $urandom % 2, $urandom % 2, rnd8());
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule